// File: doc/BRIEF.md
# SPI Memory Front End with Hold

This block is the serial face of an SPI memory device. It watches chip select, serial clock, serial data in and an active-low hold line, assembles 8-bit bytes most significant bit first, and hands the first byte of each transaction to the rest of the device as an opcode. Every later byte is handed on as a data byte. When the opcode is the status read, the block sends a status byte back on the serial output instead. It snapshots the byte from a parallel input and repeats it for as long as the host keeps clocking.

The serial pins are oversampled by the device clock through a synchronizer, so all internal state is synchronous. The hold line freezes a transaction in place. While it is active, clock and data edges are dropped and the output is released. When it is removed, shifting carries on from the same bit. Chip select still acts during hold. The output enable is meant to drive a tri-state pad. The memory array, address handling and the write timer live elsewhere.

Top module: `spi_mem_front`

## Requirements
- R1: After reset, so_oe_o is 0, and op_valid_o and data_valid_o stay 0 until a byte is completed.
- R2: The first 8 SCK rising edges after CS falls are sampled from SI, MSB first. They produce a one-cycle op_valid_o pulse with the byte on op_code_o.
- R3: so_oe_o stays 0 while the opcode byte is shifted in, while CS is high, and for the whole of any transaction whose opcode is not the status read.
- R4: After opcode 8'h05, the device clock's view of each SCK falling edge moves SO to the next bit, starting with status_i[7]. The host reads the status byte MSB first on the following 8 rising edges.
- R5: The status read is served whatever the value on status_i, including bit 0 set to mark a write in progress.
- R6: If clocking continues after the status byte, status_i is sampled afresh at the start of each further byte, and that byte is sent.
- R7: After any opcode other than 8'h05, each further 8 rising edges produce a one-cycle data_valid_o pulse with the byte on data_o.
- R8: Both SCK idle levels work: low (mode 0) and high (mode 3) while CS is high.
- R9: While hold_ni is low, SCK and SI edges are ignored and so_oe_o is 0. After release, shifting resumes at the same bit, so the byte is intact.
- R10: A change on hold_ni only takes effect while SCK is low. A hold pulse that starts and ends during one SCK-high phase has no effect.
- R11: Raising CS drops any partial byte and ends the transaction. The next transaction starts again with an opcode at bit 0.
- R12: Raising CS during hold ends the transaction and clears the hold state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Hold, active low |
| status_i | input | 8 | Status byte to return on a status read |
| so_o | output | 1 | Serial data out (0 when not enabled) |
| so_oe_o | output | 1 | Output enable for the SO pad |
| op_valid_o | output | 1 | One-cycle pulse: opcode byte complete |
| op_code_o | output | 8 | Last opcode received |
| data_valid_o | output | 1 | One-cycle pulse: data byte complete |
| data_o | output | 8 | Last data byte received |

## Verification
The bench uses the default two-stage synchronizer. It runs SCK at sixteen device clocks per period, so every pin change settles through the input delay well before the next SCK edge. This puts hold pulses inside a single SCK-high phase within reach, and the bench can sample SO mid-bit in both idle levels. Status values with the write-in-progress bit set, and a change of status between two repeated bytes, show that the snapshot is taken per byte.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] OP_RD_STAT = 8'h05;
  typedef enum logic [1:0] {PH_INSTR, PH_STATUS, PH_DATA} phase_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_s_i,
  input  logic sck_s_i,
  input  logic hold_ns_i,
  output logic held_o,
  output logic rise_o,
  output logic fall_o
);
  logic sck_q;
  logic held_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s_i;

  // hold only changes while SCK is low; CS high always clears it
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       held_q <= 1'b0;
    else if (cs_s_i)   held_q <= 1'b0;
    else if (!sck_s_i) held_q <= !hold_ns_i;

  assign held_o = held_q;
  assign rise_o = sck_s_i & ~sck_q & ~cs_s_i & ~held_q;
  assign fall_o = ~sck_s_i & sck_q & ~cs_s_i & ~held_q;

  // R10
  hold_sck_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_s_i && !cs_s_i) |=> $stable(held_q));
  // R12
  hold_cs_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |=> !held_q);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_hold_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_i,
  input  logic              si_s_i,
  input  logic              held_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              op_valid_o,
  output logic [BYTE_W-1:0] op_code_o,
  output logic              data_valid_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  phase_e            phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_q, tx_q, rx_next;
  logic              tx_act;

  assign rx_next = {rx_q[BYTE_W-2:0], si_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase        <= PH_INSTR;
      bit_cnt      <= '0;
      rx_q         <= '0;
      tx_q         <= '0;
      tx_act       <= 1'b0;
      op_valid_o   <= 1'b0;
      op_code_o    <= '0;
      data_valid_o <= 1'b0;
      data_o       <= '0;
    end else if (cs_s_i) begin
      phase        <= PH_INSTR;
      bit_cnt      <= '0;
      tx_act       <= 1'b0;
      op_valid_o   <= 1'b0;
      data_valid_o <= 1'b0;
    end else begin
      op_valid_o   <= 1'b0;
      data_valid_o <= 1'b0;
      if (rise_i) begin
        rx_q    <= rx_next;
        bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
        if (bit_cnt == LAST) begin
          unique case (phase)
            PH_INSTR: begin
              op_valid_o <= 1'b1;
              op_code_o  <= rx_next;
              phase      <= (rx_next == OP_RD_STAT) ? PH_STATUS : PH_DATA;
            end
            PH_DATA: begin
              data_valid_o <= 1'b1;
              data_o       <= rx_next;
            end
            default: ;
          endcase
        end
      end
      // fresh snapshot at the first falling edge of every status byte
      if (fall_i && phase == PH_STATUS) begin
        tx_act <= 1'b1;
        tx_q   <= (bit_cnt == '0) ? status_i : {tx_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign so_oe_o = tx_act & ~held_i & ~cs_s_i;
  assign so_o    = so_oe_o & tx_q[BYTE_W-1];

  // R2
  op_leaves_instr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> phase != PH_INSTR);
  // R3
  oe_only_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> phase == PH_STATUS);
  // R4
  tx_start_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_act) |-> (phase == PH_STATUS && bit_cnt == '0));
  // R9
  hold_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_i && !cs_s_i) |=> $stable(bit_cnt));
  // R11
  cs_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |=> (bit_cnt == '0 && !tx_act && phase == PH_INSTR));
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
  import spi_hold_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              hold_ni,
  input  logic [BYTE_W-1:0] status_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              op_valid_o,
  output logic [BYTE_W-1:0] op_code_o,
  output logic              data_valid_o,
  output logic [BYTE_W-1:0] data_o
);
  logic [3:0] pins_s;
  logic cs_s, sck_s, si_s, hold_ns;
  logic held, rise, fall;

  // order: cs, sck, si, hold ; idle values cs=1, hold=1
  spi_in_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, si_i, hold_ni}),
    .q_o   (pins_s)
  );
  assign {cs_s, sck_s, si_s, hold_ns} = pins_s;

  spi_hold_gate u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_s_i   (cs_s),
    .sck_s_i  (sck_s),
    .hold_ns_i(hold_ns),
    .held_o   (held),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  spi_shift_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_s_i      (cs_s),
    .si_s_i      (si_s),
    .held_i      (held),
    .rise_i      (rise),
    .fall_i      (fall),
    .status_i    (status_i),
    .so_o        (so_o),
    .so_oe_o     (so_oe_o),
    .op_valid_o  (op_valid_o),
    .op_code_o   (op_code_o),
    .data_valid_o(data_valid_o),
    .data_o      (data_o)
  );
endmodule

// File: tb/spi_mem_front_test.sv
module spi_mem_front_test;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic [7:0] status = 8'h00;
  logic so, so_oe, op_valid, data_valid;
  logic [7:0] op_code, data;

  int checks = 0, fails = 0;
  int op_cnt = 0, dat_cnt = 0;
  logic [7:0] last_op = 8'h00, last_dat = 8'h00;
  logic cpol = 1'b0;
  logic oe_seen = 1'b0;

  always #2.5 clk = ~clk;

  spi_mem_front uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .hold_ni(hold_n), .status_i(status), .so_o(so), .so_oe_o(so_oe),
    .op_valid_o(op_valid), .op_code_o(op_code),
    .data_valid_o(data_valid), .data_o(data)
  );

  always @(posedge clk) begin
    if (op_valid) begin op_cnt = op_cnt + 1; last_op = op_code; end
    if (data_valid) begin dat_cnt = dat_cnt + 1; last_dat = data; end
    if (so_oe) oe_seen = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_mon();
    op_cnt = 0; dat_cnt = 0; oe_seen = 1'b0;
  endtask

  task automatic begin_tx();
    sck = cpol; wclk(HALF); cs_n = 1'b0; wclk(HALF);
  endtask

  task automatic end_tx();
    wclk(HALF); cs_n = 1'b1; sck = cpol; wclk(2*HALF);
  endtask

  task automatic do_bit(input logic b, output logic so_s, output logic oe_s);
    if (!cpol) begin
      si = b; wclk(HALF); so_s = so; oe_s = so_oe; sck = 1'b1; wclk(HALF); sck = 1'b0;
    end else begin
      sck = 1'b0; si = b; wclk(HALF); so_s = so; oe_s = so_oe; sck = 1'b1; wclk(HALF);
    end
  endtask

  task automatic xfer(input logic [7:0] mosi, output logic [7:0] miso, output logic oe_any);
    logic s, o;
    oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      do_bit(mosi[i], s, o);
      miso[i] = s; oe_any = oe_any | o;
    end
  endtask

  task automatic t_reset();
    wclk(4);
    chk(so_oe == 1'b0, "R1 oe after reset", so_oe, 0);
    chk(op_valid == 1'b0 && data_valid == 1'b0, "R1 pulses after reset", {op_valid, data_valid}, 0);
  endtask

  task automatic t_rdsr(input logic mode, input logic [7:0] st);
    logic [7:0] rx; logic oe_i, oe_d;
    cpol = mode; status = st; clr_mon();
    begin_tx();
    xfer(8'h05, rx, oe_i);
    chk(oe_i == 1'b0, "R3 oe low during opcode", oe_i, 0);
    chk(op_cnt == 1 && last_op == 8'h05, "R2 opcode captured", last_op, 8'h05);
    xfer(8'h00, rx, oe_d);
    chk(rx == st, mode ? "R8 mode 3 status R4 R5" : "R4 status read mode 0 R5", rx, st);
    end_tx();
    chk(so_oe == 1'b0, "R3 oe low with CS high", so_oe, 0);
  endtask

  task automatic t_snapshot();
    logic [7:0] rx1, rx2; logic s, o;
    cpol = 1'b0; status = 8'h81; clr_mon();
    begin_tx();
    xfer(8'h05, rx1, o);
    for (int i = 7; i >= 1; i--) begin do_bit(1'b0, s, o); rx1[i] = s; end
    status = 8'h3E;
    do_bit(1'b0, s, o); rx1[0] = s;
    xfer(8'h00, rx2, o);
    end_tx();
    chk(rx1 == 8'h81, "R6 first status byte", rx1, 8'h81);
    chk(rx2 == 8'h3E, "R6 fresh snapshot", rx2, 8'h3E);
  endtask

  task automatic t_data();
    logic [7:0] rx; logic o;
    cpol = 1'b0; clr_mon();
    begin_tx();
    xfer(8'h02, rx, o);
    xfer(8'h3C, rx, o);
    chk(dat_cnt == 1 && last_dat == 8'h3C, "R7 first data byte", last_dat, 8'h3C);
    xfer(8'hC3, rx, o);
    end_tx();
    chk(dat_cnt == 2 && last_dat == 8'hC3, "R7 second data byte", last_dat, 8'hC3);
    chk(op_cnt == 1 && last_op == 8'h02, "R2 write opcode", last_op, 8'h02);
    chk(oe_seen == 1'b0, "R3 oe low for non-status", oe_seen, 0);
  endtask

  task automatic t_hold_data();
    logic [7:0] rx, b; logic s, o;
    cpol = 1'b0; clr_mon(); b = 8'h96;
    begin_tx();
    xfer(8'hA0, rx, o);
    for (int i = 7; i >= 5; i--) do_bit(b[i], s, o);
    hold_n = 1'b0; wclk(HALF);
    for (int k = 0; k < 3; k++) begin
      si = k[0]; sck = 1'b1; wclk(HALF); sck = 1'b0; wclk(HALF);
    end
    hold_n = 1'b1; wclk(HALF);
    for (int i = 4; i >= 0; i--) do_bit(b[i], s, o);
    end_tx();
    chk(dat_cnt == 1 && last_dat == 8'h96, "R9 data intact across hold", last_dat, 8'h96);
  endtask

  task automatic t_hold_status();
    logic [7:0] rx; logic s, o, oe_h;
    cpol = 1'b0; status = 8'hC9; clr_mon();
    begin_tx();
    xfer(8'h05, rx, o);
    for (int i = 7; i >= 4; i--) begin do_bit(1'b0, s, o); rx[i] = s; end
    hold_n = 1'b0; wclk(HALF);
    oe_h = so_oe;
    sck = 1'b1; wclk(HALF); sck = 1'b0; wclk(HALF);
    oe_h = oe_h | so_oe;
    hold_n = 1'b1; wclk(HALF);
    for (int i = 3; i >= 0; i--) begin do_bit(1'b0, s, o); rx[i] = s; end
    end_tx();
    chk(oe_h == 1'b0, "R9 oe low during hold", oe_h, 0);
    chk(rx == 8'hC9, "R9 status resumes same bit", rx, 8'hC9);
  endtask

  task automatic t_hold_high();
    logic [7:0] rx, b; logic s, o;
    cpol = 1'b0; clr_mon(); b = 8'h5A;
    begin_tx();
    xfer(8'h02, rx, o);
    for (int i = 7; i >= 5; i--) do_bit(b[i], s, o);
    si = b[4]; wclk(HALF); sck = 1'b1; wclk(2);
    hold_n = 1'b0; wclk(HALF); hold_n = 1'b1; wclk(HALF);
    sck = 1'b0;
    for (int i = 3; i >= 0; i--) do_bit(b[i], s, o);
    end_tx();
    chk(dat_cnt == 1 && last_dat == 8'h5A, "R10 hold during SCK high ignored", last_dat, 8'h5A);
  endtask

  task automatic t_abort();
    logic [7:0] rx; logic s, o;
    cpol = 1'b0; status = 8'h47; clr_mon();
    begin_tx();
    for (int i = 0; i < 4; i++) do_bit(1'b1, s, o);
    end_tx();
    chk(op_cnt == 0, "R11 partial byte dropped", op_cnt, 0);
    begin_tx();
    xfer(8'h05, rx, o);
    xfer(8'h00, rx, o);
    end_tx();
    chk(op_cnt == 1 && last_op == 8'h05, "R11 restart at bit 0", last_op, 8'h05);
    chk(rx == 8'h47, "R11 status after abort", rx, 8'h47);
  endtask

  task automatic t_cs_hold();
    logic [7:0] rx; logic s, o;
    cpol = 1'b0; status = 8'h12; clr_mon();
    begin_tx();
    for (int i = 0; i < 3; i++) do_bit(1'b1, s, o);
    hold_n = 1'b0; wclk(HALF);
    cs_n = 1'b1; wclk(2*HALF);
    hold_n = 1'b1; wclk(HALF);
    chk(op_cnt == 0, "R12 CS during hold ends transaction", op_cnt, 0);
    begin_tx();
    xfer(8'h05, rx, o);
    xfer(8'h00, rx, o);
    end_tx();
    chk(rx == 8'h12 && op_cnt == 1, "R12 clean start after hold abort", rx, 8'h12);
  endtask

  initial begin
    wclk(5); rst_n = 1'b1;
    t_reset();
    t_rdsr(1'b0, 8'hA5);
    t_rdsr(1'b1, 8'h63);
    t_snapshot();
    t_data();
    t_hold_data();
    t_hold_status();
    t_hold_high();
    t_abort();
    t_cs_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule